// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block executes the shift and rotate group of a small 16-bit processor without a barrel shifter. A one-cycle start pulse hands it an operand, a count, an operation code, a byte/word selector and the current flags. The unit moves the value by one bit position on every clock edge and decrements its count register on the same edge. It keeps a stall output high toward the sequencer until the count reaches zero, then pulses `done` with the result and the new flag vector.

The count comes either from an 8-bit count input, which may carry a register or an immediate value, or from a fixed-by-one selector that needs no count at all. The first bit step happens on the edge that accepts the start. A shift by one therefore completes in a single cycle and never raises the stall. A count of N takes N edges.

Top module: `shift_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `flags_we` are all 0.
- R2: When idle, a start is accepted. The effective count N is 1 if `single_shift` is set, otherwise `count_in & 5'h1F`. For N ≥ 1, `done` pulses for one cycle after exactly N rising edges counted from the accepting edge, and `busy` is high for N−1 cycles before that.
- R3: Operation encoding on `op_sel`: 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 and 6 shift left, 5 logical shift right, 7 arithmetic shift right. `result` equals the operand after N such one-bit steps.
- R4: A start that arrives while `busy` is high is ignored. The running operation completes with its original result and timing.
- R5: If N is 0, `done` pulses one cycle after the start and `busy` never rises. `result` equals the width-masked operand, `flags_out` equals `flags_in`, and `flags_we` stays 0.
- R6: With `byte_mode` set, only bits 7:0 take part, bit 7 acts as the MSB, and `result[15:8]` is 0.
- R7: Flag vector layout is bit0 CF, bit1 PF, bit2 ZF, bit3 SF, bit4 OF. For N ≥ 1, CF is the last bit shifted or rotated out.
- R8: For N = 1, OF is MSB(result) XOR CF for the left operations (0, 2, 4, 6), and MSB(result) XOR MSB(operand) for the right operations. For N > 1, OF keeps its input value.
- R9: For shift operations (codes 4 to 7) with N ≥ 1, ZF = (result over the width is zero), SF = MSB(result), and PF = 1 when result[7:0] has an even number of ones. Rotates leave PF, ZF and SF at their input values.
- R10: `flags_we` is high only in the `done` cycle, and only when `upd_flags` was set at the start and N ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; taken only when idle |
| op_sel | input | 3 | Operation code |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| single_shift | input | 1 | Fixed shift by one, ignoring `count_in` |
| count_in | input | 8 | Shift count (low 5 bits used) |
| upd_flags | input | 1 | Request flag write-back |
| operand | input | 16 | Value to shift |
| flags_in | input | 5 | Current flags {OF,SF,ZF,PF,CF} |
| busy | output | 1 | Stall to the sequencer |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted value, held until the next start |
| flags_out | output | 5 | Updated flags {OF,SF,ZF,PF,CF} |
| flags_we | output | 1 | Flag write strobe |

## Verification
The bench targets counts that trip up a step-per-cycle engine: zero, one, 31, and counts of 5 bits or more hidden above bit 4. An unmasked count would run far too long. An off-by-one counter would shift once too often and drop the 1-cycle path for single shifts. Carry rotates in byte mode with counts of 9 and more catch a carry chain that leaks into bit 8 or wraps at the wrong width. A start pulse mid-operation would, in a design without the busy guard, corrupt the result. The directed flag cases also check OF for one-bit shifts, and check that rotates keep ZF, SF and PF where a design that recomputes them would not.

// File: rtl/shift_pkg.sv
// Shared types for the iterative shift unit.
// Assumes a 5-entry flag vector and a 3-bit operation code.
package shift_pkg;

    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_ROR = 3'd1,
        OP_RCL = 3'd2,
        OP_RCR = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_SAL = 3'd6,
        OP_SAR = 3'd7
    } shift_op_e;

    localparam int NFLAGS = 5;
    localparam int FL_CF  = 0;
    localparam int FL_PF  = 1;
    localparam int FL_ZF  = 2;
    localparam int FL_SF  = 3;
    localparam int FL_OF  = 4;

    // True for operations that move bits toward the MSB.
    function automatic logic op_is_left(input shift_op_e op);
        return (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL) || (op == OP_SAL);
    endfunction

endpackage

// File: rtl/shift_step.sv
// One-bit shift/rotate step, purely combinational.
// Assumes that in byte mode the input's upper half is zero; the output's upper half is forced to zero.
module shift_step
    import shift_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] din,
    input  logic              cin,
    input  shift_op_e         op,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] dout,
    output logic              cout
);
    localparam int HALF = DATA_W / 2;

    logic              msb;
    logic              lsb;
    logic              fill;
    logic [DATA_W-1:0] raw;
    logic              left;

    // Select the incoming fill bit and compute a single-position move.
    always_comb begin
        msb  = byte_mode ? din[HALF-1] : din[DATA_W-1];
        lsb  = din[0];
        left = op_is_left(op);
        unique case (op)
            OP_ROL:  fill = msb;
            OP_ROR:  fill = lsb;
            OP_RCL:  fill = cin;
            OP_RCR:  fill = cin;
            OP_SAR:  fill = msb;
            default: fill = 1'b0;
        endcase
        if (left) begin
            raw  = {din[DATA_W-2:0], fill};
            cout = msb;
        end else begin
            raw = din >> 1;
            if (byte_mode) raw[HALF-1] = fill;
            else           raw[DATA_W-1] = fill;
            cout = lsb;
        end
        dout = byte_mode ? {{(DATA_W-HALF){1'b0}}, raw[HALF-1:0]} : raw;
    end

endmodule

// File: rtl/shift_flags.sv
// Flag generation from the final shift state.
// Assumes result is width-masked and that nz/one describe the effective count.
module shift_flags
    import shift_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  shift_op_e         op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] res,
    input  logic              cf,
    input  logic              nz,
    input  logic              one,
    input  logic              msb_orig,
    input  logic [NFLAGS-1:0] old_flags,
    output logic [NFLAGS-1:0] flags
);
    localparam int HALF = DATA_W / 2;

    logic msb_res;

    // Merge the new carry, overflow and result flags onto the old ones.
    always_comb begin
        msb_res = byte_mode ? res[HALF-1] : res[DATA_W-1];
        flags   = old_flags;
        if (nz) begin
            flags[FL_CF] = cf;
            if (one) begin
                flags[FL_OF] = op_is_left(op) ? (msb_res ^ cf) : (msb_res ^ msb_orig);
            end
            if (op[2]) begin
                flags[FL_ZF] = byte_mode ? (res[HALF-1:0] == '0) : (res == '0);
                flags[FL_SF] = msb_res;
                flags[FL_PF] = ~^res[7:0];
            end
        end
    end

endmodule

// File: rtl/shift_unit.sv
// Iterative shift/rotate execution unit: one bit per clock, stalls while counting.
// Assumes start is a single-cycle pulse; starts seen while busy are dropped.
module shift_unit
    import shift_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic              byte_mode,
    input  logic              single_shift,
    input  logic [IMM_W-1:0]  count_in,
    input  logic              upd_flags,
    input  logic [DATA_W-1:0] operand,
    input  logic [4:0]        flags_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        flags_out,
    output logic              flags_we
);
    localparam int HALF = DATA_W / 2;
    localparam logic [IMM_W-1:0] CNT_MASK = IMM_W'((1 << CNT_W) - 1);

    logic [IMM_W-1:0]  cnt_q;
    logic [DATA_W-1:0] val_q;
    logic              cf_q;
    shift_op_e         op_q;
    logic              byte_q;
    logic              upd_q;
    logic              nz_q;
    logic              one_q;
    logic              msb0_q;
    logic [NFLAGS-1:0] old_q;

    logic              accept;
    logic [IMM_W-1:0]  n_eff;
    logic [DATA_W-1:0] opnd_m;
    logic [DATA_W-1:0] step_in;
    logic              step_cin;
    shift_op_e         step_op;
    logic              step_byte;
    logic [DATA_W-1:0] step_out;
    logic              step_cout;

    // Decode the start request, effective count and the step's operands.
    always_comb begin
        accept    = start && !busy;
        n_eff     = single_shift ? IMM_W'(1) : (count_in & CNT_MASK);
        opnd_m    = byte_mode ? {{(DATA_W-HALF){1'b0}}, operand[HALF-1:0]} : operand;
        step_in   = busy ? val_q : opnd_m;
        step_cin  = busy ? cf_q : flags_in[FL_CF];
        step_op   = busy ? op_q : shift_op_e'(op_sel);
        step_byte = busy ? byte_q : byte_mode;
    end

    shift_step #(.DATA_W(DATA_W)) u_step (
        .din       (step_in),
        .cin       (step_cin),
        .op        (step_op),
        .byte_mode (step_byte),
        .dout      (step_out),
        .cout      (step_cout)
    );

    // Load on an accepted start, then step and count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt_q  <= '0;
            val_q  <= '0;
            cf_q   <= 1'b0;
            op_q   <= OP_ROL;
            byte_q <= 1'b0;
            upd_q  <= 1'b0;
            nz_q   <= 1'b0;
            one_q  <= 1'b0;
            msb0_q <= 1'b0;
            old_q  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                op_q   <= shift_op_e'(op_sel);
                byte_q <= byte_mode;
                upd_q  <= upd_flags;
                old_q  <= flags_in;
                nz_q   <= (n_eff != '0);
                one_q  <= (n_eff == IMM_W'(1));
                msb0_q <= byte_mode ? operand[HALF-1] : operand[DATA_W-1];
                if (n_eff == '0) begin
                    val_q <= opnd_m;
                    cf_q  <= flags_in[FL_CF];
                    cnt_q <= '0;
                    done  <= 1'b1;
                end else begin
                    val_q <= step_out;
                    cf_q  <= step_cout;
                    cnt_q <= n_eff - IMM_W'(1);
                    if (n_eff == IMM_W'(1)) done <= 1'b1;
                    else                    busy <= 1'b1;
                end
            end else if (busy) begin
                val_q <= step_out;
                cf_q  <= step_cout;
                cnt_q <= cnt_q - IMM_W'(1);
                if (cnt_q == IMM_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    shift_flags #(.DATA_W(DATA_W)) u_flags (
        .op        (op_q),
        .byte_mode (byte_q),
        .res       (val_q),
        .cf        (cf_q),
        .nz        (nz_q),
        .one       (one_q),
        .msb_orig  (msb0_q),
        .old_flags (old_q),
        .flags     (flags_out)
    );

    // Present the held value and the write strobe.
    always_comb begin
        result   = val_q;
        flags_we = done && upd_q && nz_q;
    end

    // R2: the stall can only end in a completion pulse.
    a_r2_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2: while stalling the count steps down by one each cycle.
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_q == $past(cnt_q) - IMM_W'(1)));

    // R4: a start during the stall leaves the captured operation alone.
    a_r4_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_q));

    // R5: zero count completes at once with no stall.
    a_r5_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !single_shift && ((count_in & CNT_MASK) == '0)) |=> (done && !busy));

    // R6: byte results never carry upper bits.
    a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && byte_q) |-> (result[DATA_W-1:HALF] == '0));

    // R10: flag strobe only in a completion cycle.
    a_r10_we_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> done);

endmodule

// File: tb/tb_shift_unit.sv
module tb_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        byte_mode = 1'b0;
    logic        single_shift = 1'b0;
    logic [7:0]  count_in = '0;
    logic        upd_flags = 1'b0;
    logic [15:0] operand = '0;
    logic [4:0]  flags_in = '0;
    logic        busy;
    logic        done;
    logic [15:0] result;
    logic [4:0]  flags_out;
    logic        flags_we;

    int checks = 0;
    int fails  = 0;

    shift_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .byte_mode(byte_mode), .single_shift(single_shift), .count_in(count_in),
        .upd_flags(upd_flags), .operand(operand), .flags_in(flags_in),
        .busy(busy), .done(done), .result(result), .flags_out(flags_out),
        .flags_we(flags_we)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: apply n one-bit steps on a w-bit value.
    function automatic void ref_op(input logic [2:0] op, input logic byt, input logic one,
                                   input logic [7:0] ci, input logic [15:0] a,
                                   input logic [4:0] fin, output logic [15:0] r,
                                   output logic [4:0] f, output int n);
        int w;
        logic [15:0] v;
        logic c, outb, top, m0, lft;
        w = byt ? 8 : 16;
        n = one ? 1 : int'(ci[4:0]);
        v = byt ? (a & 16'h00FF) : a;
        c = fin[0];
        f = fin;
        m0 = v[w-1];
        lft = (op == 3'd0) || (op == 3'd2) || (op == 3'd4) || (op == 3'd6);
        for (int i = 0; i < n; i++) begin
            if (lft) begin
                outb = v[w-1];
                v = v << 1;
                v[0] = (op == 3'd0) ? outb : (op == 3'd2) ? c : 1'b0;
                if (byt) v[15:8] = 8'h00;
                c = outb;
            end else begin
                outb = v[0];
                top = (op == 3'd1) ? outb : (op == 3'd3) ? c : (op == 3'd7) ? v[w-1] : 1'b0;
                v = v >> 1;
                v[w-1] = top;
                c = outb;
            end
        end
        r = v;
        if (n != 0) begin
            f[0] = c;
            if (n == 1) f[4] = lft ? (v[w-1] ^ c) : (v[w-1] ^ m0);
            if (op[2]) begin
                f[2] = byt ? (v[7:0] == 8'h00) : (v == 16'h0000);
                f[3] = v[w-1];
                f[1] = ~^v[7:0];
            end
        end
    endfunction

    task automatic run_op(input string tag, input logic [2:0] op, input logic byt,
                          input logic one, input logic [7:0] ci, input logic [15:0] a,
                          input logic [4:0] fin, input logic upd);
        logic [15:0] er;
        logic [4:0]  ef;
        int n, cyc, bcnt;
        ref_op(op, byt, one, ci, a, fin, er, ef, n);
        @(negedge clk);
        op_sel = op; byte_mode = byt; single_shift = one; count_in = ci;
        operand = a; flags_in = fin; upd_flags = upd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1; bcnt = 0;
        while (!done && cyc < 100) begin
            if (busy) bcnt++;
            @(negedge clk);
            cyc++;
        end
        chk({tag, " R2 latency"}, cyc, (n < 1) ? 1 : n);
        chk({tag, " R2 busy cycles"}, bcnt, (n < 2) ? 0 : n - 1);
        chk({tag, " R3 result"}, {16'h0, result}, {16'h0, er});
        chk({tag, " R7/R8/R9 flags"}, {27'h0, flags_out}, {27'h0, ef});
        chk({tag, " R10 flags_we"}, {31'h0, flags_we}, {31'h0, (upd && n != 0)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] er;
        logic [4:0]  ef;
        int n, cyc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", {31'h0, busy}, 0);
        chk("R1 done", {31'h0, done}, 0);
        chk("R1 flags_we", {31'h0, flags_we}, 0);

        // R5: zero count, count bits above bit 4 ignored
        run_op("R5 zero", 3'd4, 1'b0, 1'b0, 8'hE0, 16'hBEEF, 5'h15, 1'b1);
        run_op("R5 zero byte", 3'd2, 1'b1, 1'b0, 8'h00, 16'h12F0, 5'h0A, 1'b1);
        // single shift: one cycle, OF defined (R8)
        run_op("R8 shl1", 3'd4, 1'b0, 1'b1, 8'h1F, 16'h4000, 5'h00, 1'b1);
        run_op("R8 shr1", 3'd5, 1'b0, 1'b1, 8'h00, 16'h8001, 5'h00, 1'b1);
        run_op("R8 sar1 byte", 3'd7, 1'b1, 1'b1, 8'h00, 16'hFF81, 5'h10, 1'b1);
        // R6: byte carry rotate over more than the width
        run_op("R6 rcl9 byte", 3'd2, 1'b1, 1'b0, 8'h09, 16'hA5C3, 5'h01, 1'b1);
        run_op("R6 rcr13 byte", 3'd3, 1'b1, 1'b0, 8'h0D, 16'h0081, 5'h00, 1'b1);
        // max count, word
        run_op("R3 rol31", 3'd0, 1'b0, 1'b0, 8'h1F, 16'h8421, 5'h1F, 1'b1);
        run_op("R9 shl16 zero", 3'd4, 1'b0, 1'b0, 8'h10, 16'hFFFF, 5'h00, 1'b1);
        run_op("R9 ror keeps", 3'd1, 1'b0, 1'b0, 8'h03, 16'h0000, 5'h0E, 1'b1);
        run_op("R10 no upd", 3'd5, 1'b0, 1'b0, 8'h04, 16'hF00F, 5'h00, 1'b0);
        run_op("R7 sar word", 3'd7, 1'b0, 1'b0, 8'h05, 16'h8030, 5'h00, 1'b1);

        // R4: start mid-operation is ignored
        ref_op(3'd5, 1'b0, 1'b0, 8'h0A, 16'hC3A5, 5'h00, er, ef, n);
        @(negedge clk);
        op_sel = 3'd5; byte_mode = 1'b0; single_shift = 1'b0; count_in = 8'h0A;
        operand = 16'hC3A5; flags_in = 5'h00; upd_flags = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        repeat (2) begin @(negedge clk); cyc++; end
        op_sel = 3'd0; operand = 16'h1234; count_in = 8'h01; start = 1'b1;
        @(negedge clk);
        cyc++;
        start = 1'b0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        chk("R4 latency", cyc, n);
        chk("R4 result", {16'h0, result}, {16'h0, er});
        chk("R4 flags", {27'h0, flags_out}, {27'h0, ef});

        // random mix
        for (int k = 0; k < 300; k++) begin
            run_op("rand", 3'($urandom), 1'($urandom), ($urandom % 8) == 0,
                   8'($urandom), 16'($urandom), 5'($urandom), 1'($urandom));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule